// File: doc/BRIEF.md
# Instruction Fetch Buffer with Loop Replay

The block sits between an instruction cache and a predecode stage. It asks the cache for one packet-aligned, 16-byte packet per cycle and keeps up to four of these packets, 64 bytes in all. It shows every buffered byte to the consumer at once, as a window that starts at the current fetch byte address. Each cycle the consumer says how many bytes it took, which is at most 48 bytes (three instructions of up to 16 bytes). If the last instruction it took was a taken branch, the consumer also gives the branch target.

The same storage also holds a loop. Suppose a taken branch goes back to a byte that is still held in the buffer. The block then keeps the held packets and replays the loop body from them. While it does this, it asks the cache for nothing and turns off the branch-target lookup enable. It leaves loop mode in three cases: a redirect arrives, a taken branch points outside the loop, or the consumer moves past the closing branch without reporting it taken.

Top module: `fetch_loop_buf`

## Requirements
- R1: `cache_req_o` high means the packet at `cache_addr_o` is fetched. The block stores `cache_data_i` in that same cycle, with byte k of the packet on bits [8k+7:8k]. Requests go to consecutive packet-aligned addresses. While streaming, the request address equals `win_pc_o + win_len_o` whenever the window is not empty.
- R2: For every i below `win_len_o`, bits [8i+7:8i] of `win_data_o` hold the byte of program memory at address `win_pc_o + i`. `win_len_o` never exceeds 64.
- R3: `consume_i` (0 to 48, never above `win_len_o`) moves `win_pc_o` forward by that many bytes on the next cycle, unless a branch or redirect is taken.
- R4: Outside loop mode, a packet slot is freed only after all 16 of its bytes have been consumed. The block requests the cache exactly when a slot is free. At the ports this means `cache_req_o` equals (`win_len_o` <= 48).
- R5: Take P as `win_pc_o + consume_i`. A taken branch with `br_taken_i` high and a target that is at or above the oldest held byte and below P enters loop mode on the next cycle. `loop_active_o` then rises and the window starts at the target.
- R6: While `loop_active_o` is high, `cache_req_o` and `pred_lookup_en_o` are both low, and the held packets are replayed without change on each new pass through the loop.
- R7: Any other taken branch, such as one that points forward or at a byte no longer held, flushes the buffer. On the next cycle the window is empty, loop mode is off, and fetch restarts at the packet that holds the target.
- R8: In loop mode, consuming up to or beyond the end of the closing branch with `br_taken_i` low leaves loop mode on the next cycle. Fully consumed slots are freed and fetch resumes.
- R9: `redirect_i` flushes the buffer and clears loop mode, and it takes priority over a branch in the same cycle. The window is empty on the next cycle and then fills from the redirect address.
- R10: After reset the window is empty, loop mode is off, and the block requests the packet at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_i | input | 1 | Flush and restart fetch |
| redirect_addr_i | input | AW | Byte address to restart from |
| br_taken_i | input | 1 | The last consumed instruction was a taken branch |
| br_target_i | input | AW | Target byte address of that branch |
| consume_i | input | LEN_W | Bytes consumed this cycle |
| cache_req_o | output | 1 | Packet request to the cache |
| cache_addr_o | output | AW | Packet-aligned request address |
| cache_data_i | input | PKT_BYTES*8 | Packet returned in the same cycle |
| pred_lookup_en_o | output | 1 | Branch-target lookup enable |
| loop_active_o | output | 1 | Loop replay in progress |
| win_pc_o | output | AW | Address of window byte 0 |
| win_len_o | output | LEN_W | Number of valid window bytes |
| win_data_o | output | NSLOT*PKT_BYTES*8 | Window bytes, byte 0 in the low bits |

## Verification
A directed test captures a short loop from an unaligned start. It runs several passes and then exits. This shows whether the block replays held bytes with fetch stopped or wrongly drops back to streaming. Further directed tests cover a forward branch, a branch to a byte already released, and a redirect in the same cycle as a branch. These separate a flush from a capture and check which input wins. A long random stream then mixes variable consumption, backward and far branches, and occasional redirects. In every cycle the window bytes and address are compared with a reference memory, along with the fetch address and the fact that requests follow free-slot state. This exposes pointer, wrap and slot-freeing errors that no single directed case reaches.

// File: rtl/fbuf_pkg.sv
// Package: fbuf_pkg
// Default geometry shared by the fetch buffer modules, plus a small
// helper. Assumes power-of-two packet size and slot count.
package fbuf_pkg;
    localparam int unsigned FB_AW        = 32;
    localparam int unsigned FB_PKT_BYTES = 16;
    localparam int unsigned FB_NSLOT     = 4;
    localparam int unsigned FB_MAX_TAKE  = 48;

    // Round a byte address down to its packet boundary
    function automatic logic [FB_AW-1:0] pkt_align(input logic [FB_AW-1:0] a);
        return a & ~(FB_AW'(FB_PKT_BYTES) - FB_AW'(1));
    endfunction
endpackage

// File: rtl/fbuf_store.sv
// Module: fbuf_store
// Holds NSLOT packets in a circular array. It writes one packet per cycle
// and builds the byte window that starts at (rd_slot, head offset).
// Assumes the controller keeps the write slot outside the live window.
module fbuf_store #(
    parameter int unsigned PKT_BYTES = fbuf_pkg::FB_PKT_BYTES,
    parameter int unsigned NSLOT     = fbuf_pkg::FB_NSLOT,
    localparam int unsigned OFF_W    = $clog2(PKT_BYTES),
    localparam int unsigned SLOT_W   = $clog2(NSLOT),
    localparam int unsigned PTR_W    = OFF_W + SLOT_W,
    localparam int unsigned WIN_B    = NSLOT * PKT_BYTES
) (
    input  logic                   clk,
    input  logic                   wr_en_i,
    input  logic [SLOT_W-1:0]      wr_slot_i,
    input  logic [PKT_BYTES*8-1:0] wr_data_i,
    input  logic [SLOT_W-1:0]      rd_slot_i,
    input  logic [PTR_W-1:0]       head_i,
    output logic [WIN_B*8-1:0]     win_data_o
);
    logic [PKT_BYTES*8-1:0] pkt_q [NSLOT];

    // Capture the returned packet into its slot
    always_ff @(posedge clk) begin
        if (wr_en_i) pkt_q[wr_slot_i] <= wr_data_i;
    end

    // Rotate the circular storage so window byte 0 is the head byte
    for (genvar gi = 0; gi < WIN_B; gi++) begin : g_win
        logic [PTR_W-1:0]  pos;
        logic [SLOT_W-1:0] sl;
        assign pos = head_i + PTR_W'(gi);
        assign sl  = rd_slot_i + pos[OFF_W +: SLOT_W];
        assign win_data_o[gi*8 +: 8] = pkt_q[sl][{pos[OFF_W-1:0], 3'b000} +: 8];
    end
endmodule

// File: rtl/fbuf_ctrl.sv
// Module: fbuf_ctrl
// Pointer and mode control. It tracks the oldest held packet (base address
// and slot), the consumed byte offset, the slot count, and loop capture and
// exit. It gates cache requests. Assumes consume_i <= window length and
// <= MAX_TAKE, and that a taken branch ends within the consumed bytes.
module fbuf_ctrl #(
    parameter int unsigned AW        = fbuf_pkg::FB_AW,
    parameter int unsigned PKT_BYTES = fbuf_pkg::FB_PKT_BYTES,
    parameter int unsigned NSLOT     = fbuf_pkg::FB_NSLOT,
    parameter int unsigned MAX_TAKE  = fbuf_pkg::FB_MAX_TAKE,
    localparam int unsigned OFF_W    = $clog2(PKT_BYTES),
    localparam int unsigned SLOT_W   = $clog2(NSLOT),
    localparam int unsigned PTR_W    = OFF_W + SLOT_W,
    localparam int unsigned CNT_W    = SLOT_W + 1,
    localparam int unsigned WIN_B    = NSLOT * PKT_BYTES,
    localparam int unsigned LEN_W    = $clog2(WIN_B + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_i,
    input  logic [AW-1:0]     redirect_addr_i,
    input  logic              br_taken_i,
    input  logic [AW-1:0]     br_target_i,
    input  logic [LEN_W-1:0]  consume_i,
    output logic              cache_req_o,
    output logic [AW-1:0]     cache_addr_o,
    output logic              wr_en_o,
    output logic [SLOT_W-1:0] wr_slot_o,
    output logic [SLOT_W-1:0] rd_slot_o,
    output logic [PTR_W-1:0]  head_o,
    output logic [LEN_W-1:0]  win_len_o,
    output logic [AW-1:0]     win_pc_o,
    output logic              loop_o
);
    localparam int unsigned FR_W = LEN_W + 1 - OFF_W;

    logic [AW-1:0]     base_q, base_n;
    logic [LEN_W-1:0]  hd_q, hd_n;
    logic [LEN_W-1:0]  lend_q, lend_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [SLOT_W-1:0] rd_q, rd_n;
    logic              loop_q, loop_n;

    logic [LEN_W-1:0]  res_bytes;
    logic [LEN_W:0]    hd_adv;
    logic [AW-1:0]     tgt_off;
    logic              tgt_in;
    logic              fill;
    logic [CNT_W-1:0]  cnt_fill;
    logic [FR_W-1:0]   freed;

    // Bytes held, head after consumption, and residency test for a branch target
    always_comb begin
        res_bytes = LEN_W'(cnt_q) << OFF_W;
        hd_adv    = {1'b0, hd_q} + {1'b0, consume_i};
        tgt_off   = br_target_i - base_q;
        tgt_in    = (br_target_i >= base_q) && (tgt_off < AW'(res_bytes))
                    && (tgt_off < AW'(hd_adv));
        fill      = cache_req_o;
        cnt_fill  = cnt_q + CNT_W'(fill);
    end

    // Next-state selection: redirect, loop capture, flush, replay, stream
    always_comb begin
        base_n = base_q;
        hd_n   = hd_q;
        lend_n = lend_q;
        cnt_n  = cnt_q;
        rd_n   = rd_q;
        loop_n = loop_q;
        freed  = '0;
        if (redirect_i) begin
            base_n = fbuf_pkg::pkt_align(redirect_addr_i);
            hd_n   = LEN_W'(redirect_addr_i[OFF_W-1:0]);
            cnt_n  = '0;
            loop_n = 1'b0;
        end else if (br_taken_i && tgt_in) begin
            loop_n = 1'b1;
            lend_n = hd_adv[LEN_W-1:0];
            hd_n   = tgt_off[LEN_W-1:0];
            cnt_n  = cnt_fill;
        end else if (br_taken_i) begin
            base_n = fbuf_pkg::pkt_align(br_target_i);
            hd_n   = LEN_W'(br_target_i[OFF_W-1:0]);
            cnt_n  = '0;
            loop_n = 1'b0;
        end else if (loop_q && (hd_adv < {1'b0, lend_q})) begin
            hd_n   = hd_adv[LEN_W-1:0];
            cnt_n  = cnt_fill;
        end else begin
            loop_n = 1'b0;
            freed  = hd_adv[LEN_W:OFF_W];
            base_n = base_q + (AW'(freed) << OFF_W);
            rd_n   = rd_q + freed[SLOT_W-1:0];
            hd_n   = LEN_W'(hd_adv[OFF_W-1:0]);
            cnt_n  = cnt_fill - CNT_W'(freed);
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            hd_q   <= '0;
            lend_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            loop_q <= 1'b0;
        end else begin
            base_q <= base_n;
            hd_q   <= hd_n;
            lend_q <= lend_n;
            cnt_q  <= cnt_n;
            rd_q   <= rd_n;
            loop_q <= loop_n;
        end
    end

    // Output decode from registered state
    always_comb begin
        cache_req_o  = !loop_q && (cnt_q < CNT_W'(NSLOT));
        cache_addr_o = base_q + (AW'(cnt_q) << OFF_W);
        wr_en_o      = fill;
        wr_slot_o    = rd_q + cnt_q[SLOT_W-1:0];
        rd_slot_o    = rd_q;
        head_o       = hd_q[PTR_W-1:0];
        win_len_o    = (res_bytes > hd_q) ? (res_bytes - hd_q) : '0;
        win_pc_o     = base_q + AW'(hd_q);
        loop_o       = loop_q;
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NSLOT)); // R1
    AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} <= {1'b0, $past(cnt_q)} + 1'b1); // R1
    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_len_o <= LEN_W'(WIN_B)); // R2
    AST_CONSUME_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i <= win_len_o) && (consume_i <= LEN_W'(MAX_TAKE))); // R3
    AST_LOOP_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_q && $past(loop_q)) |-> (cnt_q == $past(cnt_q))); // R6
    AST_LOOP_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_q && $past(loop_q)) |-> $stable(base_q)); // R6
    AST_REDIRECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> ((win_len_o == '0) && !loop_q)); // R9
endmodule

// File: rtl/fetch_loop_buf.sv
// Module: fetch_loop_buf
// Top of the fetch buffer. It wires the controller to the packet store and
// exposes the cache request, the byte window and the loop status. Assumes
// the cache returns the requested packet in the same cycle.
module fetch_loop_buf #(
    parameter int unsigned AW        = fbuf_pkg::FB_AW,
    parameter int unsigned PKT_BYTES = fbuf_pkg::FB_PKT_BYTES,
    parameter int unsigned NSLOT     = fbuf_pkg::FB_NSLOT,
    parameter int unsigned MAX_TAKE  = fbuf_pkg::FB_MAX_TAKE,
    localparam int unsigned OFF_W    = $clog2(PKT_BYTES),
    localparam int unsigned SLOT_W   = $clog2(NSLOT),
    localparam int unsigned PTR_W    = OFF_W + SLOT_W,
    localparam int unsigned WIN_B    = NSLOT * PKT_BYTES,
    localparam int unsigned LEN_W    = $clog2(WIN_B + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   redirect_i,
    input  logic [AW-1:0]          redirect_addr_i,
    input  logic                   br_taken_i,
    input  logic [AW-1:0]          br_target_i,
    input  logic [LEN_W-1:0]       consume_i,
    output logic                   cache_req_o,
    output logic [AW-1:0]          cache_addr_o,
    input  logic [PKT_BYTES*8-1:0] cache_data_i,
    output logic                   pred_lookup_en_o,
    output logic                   loop_active_o,
    output logic [AW-1:0]          win_pc_o,
    output logic [LEN_W-1:0]       win_len_o,
    output logic [WIN_B*8-1:0]     win_data_o
);
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;
    logic [PTR_W-1:0]  head;
    logic              loop_st;

    fbuf_ctrl #(.AW(AW), .PKT_BYTES(PKT_BYTES), .NSLOT(NSLOT), .MAX_TAKE(MAX_TAKE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .redirect_i(redirect_i), .redirect_addr_i(redirect_addr_i),
        .br_taken_i(br_taken_i), .br_target_i(br_target_i),
        .consume_i(consume_i),
        .cache_req_o(cache_req_o), .cache_addr_o(cache_addr_o),
        .wr_en_o(wr_en), .wr_slot_o(wr_slot), .rd_slot_o(rd_slot),
        .head_o(head), .win_len_o(win_len_o), .win_pc_o(win_pc_o),
        .loop_o(loop_st)
    );

    fbuf_store #(.PKT_BYTES(PKT_BYTES), .NSLOT(NSLOT)) u_store (
        .clk(clk), .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_data_i(cache_data_i),
        .rd_slot_i(rd_slot), .head_i(head), .win_data_o(win_data_o)
    );

    // Loop status and the matching suppression of branch-target lookups
    always_comb begin
        loop_active_o    = loop_st;
        pred_lookup_en_o = !loop_st;
    end

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active_o |-> (!cache_req_o && !pred_lookup_en_o)); // R6
    AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_i && br_taken_i) |=> !loop_active_o); // R9
endmodule

// File: tb/tb_fetch_loop_buf.sv
// Bench for fetch_loop_buf: directed loop, flush and priority cases followed
// by seeded random streaming. Every check compares against a reference memory.
module tb_fetch_loop_buf;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int PB = 16;
    localparam int WB = 64;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redirect = 1'b0;
    logic [AW-1:0] redirect_addr = '0;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [LW-1:0] consume = '0;
    logic          cache_req;
    logic [AW-1:0] cache_addr;
    logic [PB*8-1:0] cache_data;
    logic          pred_en;
    logic          loop_act;
    logic [AW-1:0] win_pc;
    logic [LW-1:0] win_len;
    logic [WB*8-1:0] win_data;

    int vecs = 0;
    int errs = 0;
    bit done = 0;
    logic [AW-1:0] exp_pc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_loop_buf dut (
        .clk(clk), .rst_n(rst_n), .redirect_i(redirect), .redirect_addr_i(redirect_addr),
        .br_taken_i(br_taken), .br_target_i(br_target), .consume_i(consume),
        .cache_req_o(cache_req), .cache_addr_o(cache_addr), .cache_data_i(cache_data),
        .pred_lookup_en_o(pred_en), .loop_active_o(loop_act),
        .win_pc_o(win_pc), .win_len_o(win_len), .win_data_o(win_data)
    );

    function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
        logic [AW-1:0] t;
        t = a * 32'd2654435761;
        return t[23:16] ^ a[7:0];
    endfunction

    // Reference cache: returns the requested packet in the same cycle
    always_comb begin
        for (int b = 0; b < PB; b++) cache_data[b*8 +: 8] = mem_b(cache_addr + AW'(b));
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // Per-cycle checks on window content, address, request gating
    task automatic stream_checks();
        int bad;
        bad = -1;
        for (int i = 0; i < int'(win_len); i++)
            if (bad < 0 && win_data[i*8 +: 8] !== mem_b(win_pc + AW'(i))) bad = i;
        chk(bad < 0, "R2 window bytes", bad, -1);
        chk(win_len <= LW'(WB), "R2 window length", win_len, WB);
        if (win_len != 0) chk(win_pc == exp_pc, "R3 window pc", win_pc, exp_pc);
        if (!loop_act) begin
            chk(cache_req == (win_len <= 48), "R4 request iff free slot", cache_req, win_len <= 48);
            if (win_len != 0)
                chk(cache_addr == win_pc + AW'(win_len), "R1 fetch address", cache_addr, win_pc + AW'(win_len));
        end else begin
            chk(!cache_req && !pred_en, "R6 quiet in loop", {cache_req, pred_en}, 0);
        end
    endtask

    task automatic cyc(input int c, input bit tk, input logic [AW-1:0] tg,
                       input bit rd, input logic [AW-1:0] ra);
        consume = LW'(c); br_taken = tk; br_target = tg; redirect = rd; redirect_addr = ra;
        @(posedge clk);
        @(negedge clk);
        consume = '0; br_taken = 1'b0; redirect = 1'b0;
        if (rd) exp_pc = ra;
        else if (tk) exp_pc = tg;
        else exp_pc = exp_pc + AW'(c);
        stream_checks();
    endtask

    task automatic fill_up(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, '0, 0, '0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int c;
        int r;
        logic [AW-1:0] tg;
        void'($urandom(32'd1337));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: state held in reset
        chk(win_len == 0 && !loop_act, "R10 reset window", {win_len, loop_act}, 0);
        chk(cache_req && cache_addr == 0, "R10 reset request", cache_addr, 0);
        rst_n = 1'b1;
        exp_pc = '0;

        // R5/R6/R8 directed loop from an unaligned start
        cyc(0, 0, '0, 1, 32'h1004);
        chk(win_len == 0, "R9 empty after redirect", win_len, 0);
        fill_up(4);
        chk(win_len == 60 && !cache_req, "R4 full buffer", win_len, 60);
        cyc(36, 1, 32'h100C, 0, '0);
        chk(loop_act, "R5 loop entered", loop_act, 1);
        chk(win_pc == 32'h100C, "R5 window at target", win_pc, 32'h100C);
        for (int p = 0; p < 3; p++) begin
            cyc(20, 0, '0, 0, '0);
            cyc(8, 1, 32'h100C, 0, '0);
            chk(loop_act && !cache_req, "R6 replay pass", loop_act, 1);
        end
        cyc(28, 0, '0, 0, '0);
        chk(!loop_act, "R8 loop exit", loop_act, 0);
        chk(win_pc == 32'h1028 && cache_req, "R8 fetch resumes", win_pc, 32'h1028);

        // R7 forward branch inside the buffer flushes
        fill_up(3);
        cyc(4, 1, exp_pc + 32'd20, 0, '0);
        chk(!loop_act && win_len == 0, "R7 forward flush", win_len, 0);
        chk(cache_addr == (exp_pc & ~32'hF), "R7 restart address", cache_addr, exp_pc & ~32'hF);
        fill_up(4);
        // R7 backward to an already released byte
        cyc(40, 0, '0, 0, '0);
        tg = exp_pc - 32'd30;
        cyc(4, 1, tg, 0, '0);
        chk(!loop_act && win_len == 0, "R7 released target flush", win_len, 0);
        fill_up(4);
        // R9 redirect beats a capturable branch, also clears loop mode
        cyc(10, 1, exp_pc + 32'd2, 0, '0);
        chk(loop_act, "R5 second capture", loop_act, 1);
        cyc(4, 1, exp_pc, 1, 32'h2233);
        chk(!loop_act && win_len == 0, "R9 redirect priority", win_len, 0);
        chk(cache_addr == 32'h2230, "R9 restart address", cache_addr, 32'h2230);
        fill_up(2);

        // Seeded random streaming with backward and far branches
        for (int n = 0; n < 4000; n++) begin
            c = int'(win_len) < 48 ? int'(win_len) : 48;
            c = (c == 0) ? 0 : int'($urandom_range(c, 0));
            r = int'($urandom_range(99, 0));
            if (r < 2) cyc(0, 0, '0, 1, $urandom_range(32'hFFFF, 0));
            else if (c > 0 && r < 20) cyc(c, 1, exp_pc + AW'(c) - AW'($urandom_range(40, 1)), 0, '0);
            else if (c > 0 && r < 24) cyc(c, 1, $urandom_range(32'hFFFF, 0), 0, '0);
            else cyc(c, 0, '0, 0, '0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule